// File: doc/BRIEF.md
# Program Counter and Return Stack

This block produces the instruction fetch address for a small core with a two-stage pipeline, in which one instruction is fetched while the one before it executes. It holds a 13-bit counter that always points at the next word to fetch, a 5-bit page latch that supplies the upper address bits for absolute transfers, and an eight-entry return-address stack. Each cycle the execute stage presents one decoded control code, and the block picks the next counter value from that code.

Any transfer of control makes the word that was already fetched useless. The block reports this by raising `flush` for one cycle, and the execute stage turns the instruction it holds into a no-op. While `flush` is high the block ignores the control code and simply advances. As a result every taken transfer costs exactly two cycles.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-low reset sets `fetch_addr` to 0000h, `flush` to 0, `latch_rdata` to 0 and the stack pointer to its first slot.
- R2: With control code 0 (sequential), `fetch_addr` advances by one per cycle. It crosses 2K page boundaries with no restriction and wraps from 1FFFh to 0000h.
- R3: Control code 1 (jump) loads `fetch_addr` with page latch bits 4:3 as address bits 12:11 and `ctl_lit` as bits 10:0.
- R4: Codes 1, 2, 3, 4, 5 and 6 raise `flush` in the next cycle for exactly one cycle. During that cycle the control inputs are ignored and the counter advances by one.
- R5: Control code 2 (call) pushes the current `fetch_addr` and jumps the same way as R3. Control code 3 (return) loads the most recently pushed address and removes it from the stack.
- R6: The stack holds 8 entries and works last-in first-out. A ninth push overwrites the oldest entry, so after nine calls, nine returns give the pushed addresses in the order 9th, 8th down to 2nd, and then the 9th again.
- R7: Control code 4 (taken skip) advances the counter by one and flushes.
- R8: Control code 5 (low-byte write) loads `fetch_addr` with all 5 page latch bits as bits 12:8 and `pcl_wdata` as bits 7:0.
- R9: Control code 6 (interrupt accept) pushes the current `fetch_addr` and loads 0004h.
- R10: `pcl_rdata` always equals `fetch_addr[7:0]`. The page latch changes only when `latch_we` is high, and it then takes `latch_wdata[4:0]`. A transfer in the same cycle as a latch write uses the old latch value.
- R11: Control code 7 is reserved and behaves as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_op | input | 3 | Decoded control code from the execute stage |
| ctl_lit | input | 11 | Address field of a jump or call word |
| pcl_wdata | input | 8 | Data written to the low counter byte |
| latch_we | input | 1 | Write strobe for the page latch |
| latch_wdata | input | 8 | Data for the page latch (bits 4:0 are kept) |
| fetch_addr | output | 13 | Address of the next word to fetch |
| flush | output | 1 | Instruction now in execute must be treated as a no-op |
| pcl_rdata | output | 8 | Read value of the low counter byte |
| latch_rdata | output | 5 | Current page latch contents |

## Verification
A wrong counter value shows on `fetch_addr` in the first cycle after the bad update. A stuck or missing flush shows one cycle after the transfer, through `flush` itself or through an extra increment. A corrupt stack pointer or entry stays hidden until the matching return, which can be many cycles later. The bench therefore nests calls, overflows the stack, and returns all the way back. A page latch fault shows only at the next jump or low-byte write, so every latch write is followed by such a transfer.

// File: rtl/pcseq_pkg.sv
// Package: shared control-code type for the program counter sequencer.
// Assumes a 3-bit code produced by the execute-stage decoder.
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JUMP = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_SKIP = 3'd4,
        OP_PCLW = 3'd5,
        OP_IRQ  = 3'd6,
        OP_RSVD = 3'd7
    } op_t;
endpackage

// File: rtl/pcseq_stack.sv
// Circular return-address stack.
// Each push writes the slot at the pointer and advances it; each pop steps it back.
// Assumes DEPTH is a power of two, so the pointer wraps naturally and a push
// beyond DEPTH overwrites the oldest entry. Push and pop never come together.
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic [W-1:0]     slot_q [DEPTH];

    // Pointer: advance on push, step back on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (push)
            ptr_q <= ptr_q + PTR_ONE;
        else if (pop)
            ptr_q <= ptr_q - PTR_ONE;
    end

    // Entry storage: one register per slot, written when the pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push && (ptr_q == PTR_W'(g)))
                slot_q[g] <= push_data;
        end
    end

    // Top of stack: the slot just below the pointer.
    always_comb top_data = slot_q[ptr_q - PTR_ONE];
endmodule

// File: rtl/pcseq_next.sv
// Next-address selection for the program counter.
// Picks the next counter value from the effective control code and says
// whether the stack is pushed or popped and whether a flush must follow.
// Assumes the caller already forced the code to sequential during a flush cycle.
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LIT_W   = 11,
    parameter int DATA_W  = 8,
    parameter int LATCH_W = 5,
    parameter int IRQ_VEC = 4
) (
    input  op_t                op,
    input  logic [PC_W-1:0]    pc,
    input  logic [LIT_W-1:0]   lit,
    input  logic [DATA_W-1:0]  pcl_wdata,
    input  logic [LATCH_W-1:0] latch,
    input  logic [PC_W-1:0]    stk_top,
    output logic [PC_W-1:0]    pc_nxt,
    output logic               push,
    output logic               pop,
    output logic               xfer
);
    localparam int PAGE_W  = PC_W - LIT_W;
    localparam int HI_W    = PC_W - DATA_W;
    localparam int PAGE_LO = LIT_W - DATA_W;
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);
    localparam logic [PC_W-1:0] IRQ_A  = PC_W'(IRQ_VEC);

    logic [PC_W-1:0] abs_tgt;
    logic [PC_W-1:0] byte_tgt;
    logic [PC_W-1:0] inc_pc;

    // Candidate addresses: paged absolute, low-byte write, increment.
    always_comb begin
        abs_tgt  = {latch[PAGE_LO +: PAGE_W], lit};
        byte_tgt = {latch[HI_W-1:0], pcl_wdata};
        inc_pc   = pc + PC_ONE;
    end

    // Select by control code and flag stack use and flush.
    always_comb begin
        pc_nxt = inc_pc;
        push   = 1'b0;
        pop    = 1'b0;
        xfer   = 1'b0;
        unique case (op)
            OP_JUMP: begin pc_nxt = abs_tgt;  xfer = 1'b1; end
            OP_CALL: begin pc_nxt = abs_tgt;  xfer = 1'b1; push = 1'b1; end
            OP_RET:  begin pc_nxt = stk_top;  xfer = 1'b1; pop  = 1'b1; end
            OP_SKIP: begin pc_nxt = inc_pc;   xfer = 1'b1; end
            OP_PCLW: begin pc_nxt = byte_tgt; xfer = 1'b1; end
            OP_IRQ:  begin pc_nxt = IRQ_A;    xfer = 1'b1; push = 1'b1; end
            default: begin pc_nxt = inc_pc; end
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Program counter, page latch and return stack for a two-stage core.
// fetch_addr always names the next word to fetch. A transfer raises flush for
// the following cycle, and the control code is ignored in that cycle.
// Assumes the execute stage presents one code per cycle and issues no push
// and pop together.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LIT_W     = 11,
    parameter int DATA_W    = 8,
    parameter int LATCH_W   = 5,
    parameter int DEPTH     = 8,
    parameter int RESET_VEC = 0,
    parameter int IRQ_VEC   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ctl_op,
    input  logic [LIT_W-1:0]   ctl_lit,
    input  logic [DATA_W-1:0]  pcl_wdata,
    input  logic               latch_we,
    input  logic [DATA_W-1:0]  latch_wdata,
    output logic [PC_W-1:0]    fetch_addr,
    output logic               flush,
    output logic [DATA_W-1:0]  pcl_rdata,
    output logic [LATCH_W-1:0] latch_rdata
);
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    pc_nxt;
    logic [LATCH_W-1:0] latch_q;
    logic               flush_q;
    logic               push;
    logic               pop;
    logic               xfer;
    logic [PC_W-1:0]    stk_top;
    op_t                op_eff;

    // Effective code: a flushed slot behaves as sequential.
    always_comb op_eff = flush_q ? OP_SEQ : op_t'(ctl_op);

    pcseq_next #(
        .PC_W(PC_W), .LIT_W(LIT_W), .DATA_W(DATA_W),
        .LATCH_W(LATCH_W), .IRQ_VEC(IRQ_VEC)
    ) u_next (
        .op(op_eff), .pc(pc_q), .lit(ctl_lit), .pcl_wdata(pcl_wdata),
        .latch(latch_q), .stk_top(stk_top),
        .pc_nxt(pc_nxt), .push(push), .pop(pop), .xfer(xfer)
    );

    pcseq_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(pc_q), .top_data(stk_top)
    );

    // Counter and flush registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= PC_W'(RESET_VEC);
            flush_q <= 1'b0;
        end else begin
            pc_q    <= pc_nxt;
            flush_q <= xfer;
        end
    end

    // Page latch: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (latch_we)
            latch_q <= latch_wdata[LATCH_W-1:0];
    end

    // Output views of the state.
    always_comb begin
        fetch_addr  = pc_q;
        flush       = flush_q;
        pcl_rdata   = pc_q[DATA_W-1:0];
        latch_rdata = latch_q;
    end
endmodule

// File: rtl/pc_sequencer_chk.sv
// Port-level property checker for pc_sequencer, attached with bind.
module pc_sequencer_chk
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LIT_W   = 11,
    parameter int DATA_W  = 8,
    parameter int LATCH_W = 5,
    parameter int IRQ_VEC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         ctl_op,
    input logic [LIT_W-1:0]   ctl_lit,
    input logic [DATA_W-1:0]  pcl_wdata,
    input logic               latch_we,
    input logic [PC_W-1:0]    fetch_addr,
    input logic               flush,
    input logic [LATCH_W-1:0] latch_rdata
);
    localparam int PAGE_LO = LIT_W - DATA_W;
    localparam int PAGE_W  = PC_W - LIT_W;
    localparam int HI_W    = PC_W - DATA_W;

    logic is_xfer;
    always_comb is_xfer = (ctl_op != OP_SEQ) && (ctl_op != OP_RSVD);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (ctl_op == OP_SEQ)) |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)) && !flush);

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (ctl_op == OP_JUMP)) |=>
        (fetch_addr == {$past(latch_rdata[PAGE_LO +: PAGE_W]), $past(ctl_lit)}));

    // R4
    flush_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && is_xfer) |=> flush);

    // R4
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && (fetch_addr == $past(fetch_addr) + PC_W'(1))));

    // R7
    skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (ctl_op == OP_SKIP)) |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)));

    // R8
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (ctl_op == OP_PCLW)) |=>
        (fetch_addr == {$past(latch_rdata[HI_W-1:0]), $past(pcl_wdata)}));

    // R9
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (ctl_op == OP_IRQ)) |=> (fetch_addr == PC_W'(IRQ_VEC)));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_we |=> $stable(latch_rdata));
endmodule

bind pc_sequencer pc_sequencer_chk #(
    .PC_W(PC_W), .LIT_W(LIT_W), .DATA_W(DATA_W),
    .LATCH_W(LATCH_W), .IRQ_VEC(IRQ_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .ctl_lit(ctl_lit),
    .pcl_wdata(pcl_wdata), .latch_we(latch_we), .fetch_addr(fetch_addr),
    .flush(flush), .latch_rdata(latch_rdata)
);

// File: tb/pc_sequencer_bench.sv
// Scoreboard bench: the driver models each cycle and queues the expected
// outputs; the monitor pops and compares them on the falling edge.
module pc_sequencer_bench;
    localparam int CLK_P = 10;

    typedef struct {
        logic [12:0] addr;
        logic        fl;
        logic [4:0]  lat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl_op = '0;
    logic [10:0] ctl_lit = '0;
    logic [7:0]  pcl_wdata = '0;
    logic        latch_we = 1'b0;
    logic [7:0]  latch_wdata = '0;
    logic [12:0] fetch_addr;
    logic        flush;
    logic [7:0]  pcl_rdata;
    logic [4:0]  latch_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    exp_t q[$];

    logic [12:0] m_pc = '0;
    logic        m_fl = 1'b0;
    logic [4:0]  m_lat = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #(CLK_P/2) clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .ctl_lit(ctl_lit),
        .pcl_wdata(pcl_wdata), .latch_we(latch_we), .latch_wdata(latch_wdata),
        .fetch_addr(fetch_addr), .flush(flush), .pcl_rdata(pcl_rdata),
        .latch_rdata(latch_rdata)
    );

    // Monitor: compare outputs against the oldest queued expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (fetch_addr !== e.addr || flush !== e.fl || latch_rdata !== e.lat
                || pcl_rdata !== e.addr[7:0]) begin
                n_bad++;
                $display("FAIL %s: addr=%h flush=%b latch=%h pcl=%h expected addr=%h flush=%b latch=%h pcl=%h",
                         e.tag, fetch_addr, flush, latch_rdata, pcl_rdata,
                         e.addr, e.fl, e.lat, e.addr[7:0]);
            end
        end
    end

    // Driver: apply one cycle of stimulus, advance the model, queue the result.
    task automatic step(input logic [2:0] op, input logic [10:0] lit,
                        input logic [7:0] wd, input logic lwe,
                        input logic [7:0] lwd, input string tag);
        logic [2:0]  eop;
        logic [12:0] npc;
        logic        nfl;
        exp_t        e;
        ctl_op = op; ctl_lit = lit; pcl_wdata = wd;
        latch_we = lwe; latch_wdata = lwd;
        eop = (m_fl || op == 3'd7) ? 3'd0 : op;
        npc = m_pc + 13'd1;
        nfl = 1'b1;
        case (eop)
            3'd1: npc = {m_lat[4:3], lit};
            3'd2: begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; npc = {m_lat[4:3], lit}; end
            3'd3: begin m_sp = (m_sp + 7) % 8; npc = m_stk[m_sp]; end
            3'd4: npc = m_pc + 13'd1;
            3'd5: npc = {m_lat, wd};
            3'd6: begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; npc = 13'h0004; end
            default: nfl = 1'b0;
        endcase
        if (lwe) m_lat = lwd[4:0];
        m_pc = npc;
        m_fl = nfl;
        @(posedge clk);
        #1;
        e.addr = m_pc; e.fl = m_fl; e.lat = m_lat; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic seq(input string tag);
        step(3'd0, '0, '0, 1'b0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (fetch_addr !== 13'h0000 || flush !== 1'b0 || latch_rdata !== 5'h00) begin
            n_bad++;
            $display("FAIL R1: addr=%h flush=%b latch=%h expected 0000 0 00",
                     fetch_addr, flush, latch_rdata);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) seq("R2");
        // R10: latch write, then R8 low-byte write to 1FFF
        step(3'd0, '0, '0, 1'b1, 8'hFF, "R10");
        step(3'd5, '0, 8'hFF, 1'b0, '0, "R8");
        // R4: jump during flush is ignored; counter wraps to 0000 (R2)
        step(3'd1, 11'h555, '0, 1'b0, '0, "R4");
        seq("R2");
        // R3: latch bits 4:3 = 01, jump to 0FFE, then cross page (R2)
        step(3'd0, '0, '0, 1'b1, 8'h08, "R10");
        step(3'd1, 11'h7FE, '0, 1'b0, '0, "R3");
        seq("R4");
        seq("R2");
        seq("R2");
        // R5: nested calls and returns
        step(3'd2, 11'h123, '0, 1'b0, '0, "R5");
        seq("R4");
        step(3'd2, 11'h200, '0, 1'b0, '0, "R5");
        seq("R4");
        seq("R5");
        step(3'd3, '0, '0, 1'b0, '0, "R5");
        seq("R4");
        step(3'd3, '0, '0, 1'b0, '0, "R5");
        seq("R4");
        // R7: taken skip
        step(3'd4, '0, '0, 1'b0, '0, "R7");
        step(3'd3, '0, '0, 1'b0, '0, "R7");
        // R9: interrupt accept and return
        step(3'd6, '0, '0, 1'b0, '0, "R9");
        seq("R4");
        step(3'd3, '0, '0, 1'b0, '0, "R9");
        seq("R4");
        // R6: nine calls overflow the stack, then nine returns
        for (int i = 0; i < 9; i++) begin
            step(3'd2, 11'(11'h100 + 11'(i * 16)), '0, 1'b0, '0, "R6");
            seq("R6");
        end
        for (int i = 0; i < 9; i++) begin
            step(3'd3, '0, '0, 1'b0, '0, "R6");
            seq("R6");
        end
        // R10: jump in the same cycle as a latch write uses the old latch
        step(3'd1, 11'h011, '0, 1'b1, 8'h18, "R10");
        seq("R4");
        step(3'd1, 11'h022, '0, 1'b0, '0, "R10");
        // R11: reserved code behaves as sequential
        step(3'd7, 11'h3FF, 8'hAA, 1'b0, '0, "R11");
        step(3'd7, 11'h3FF, 8'hAA, 1'b0, '0, "R11");
        // R8: low-byte write with latch 18
        step(3'd5, '0, 8'h3C, 1'b0, '0, "R8");
        seq("R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule